// File: doc/BRIEF.md
# Scan-chain register access port

This block sits behind a test access port controller and turns one data-register scan path into read and write accesses on a small parallel register bus. A debugger shifts a 40-bit frame through the block. The frame holds a write value, a register number from a 128-entry space, and a direction flag. When the controller sends its update strobe, the block performs that access on the bus.

Reads are pipelined by one scan. The value fetched at an update is loaded into the shift path at the next capture strobe and leaves on the serial output during the next scan. Every read therefore needs one more scan behind it. That closing scan should read register 0, the identification register, because register 0 has no side effect. A block read from a register with a read side effect, such as a trace memory data port, repeats that register's number in every scan except the last one, which uses 0.

The controller state machine is outside the block. The block only sees the capture, shift and update strobes. Each strobe is a one-cycle enable in the block's clock domain.

Top module: `scan_reg_port`

## Requirements
- R1: Frame layout, counting from the bit that is shifted first: bits [31:0] are the data field, bits [38:32] are the register number and bit [39] is the direction flag. All register numbers from 0 to 127 reach the bus unchanged.
- R2: In each cycle with `shift_en` high, `tdi` enters at bit 39 and every other bit moves down by one place. `tdo` always shows bit 0, so a frame leaves least significant bit first.
- R3: If the direction flag is 1, an update issues exactly one cycle of `bus_req` with `bus_wr`=1, the register number on `bus_addr` and the data field on `bus_wdata`.
- R4: If the direction flag is 0, an update issues one cycle of `bus_req` with `bus_wr`=0 and the register number on `bus_addr`. `bus_rdata` is sampled in that same cycle.
- R5: A capture loads the shift path with the last read value in bits [31:0], the number of the register it came from in bits [38:32], and 0 in bit 39. The data of a read therefore comes out during the scan that follows it.
- R6: An update with no shift cycle since the last capture or update issues no bus access.
- R7: After reset, `tdo` is 0, `bus_req` is low and the first captured frame is all zeros.
- R8: A write access leaves the stored read result unchanged, so the next capture still returns the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_en | input | 1 | Capture strobe from the controller |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| upd_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift path) |
| bus_req | output | 1 | One-cycle access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 7 | Register number |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled while a read request is high |

## Verification
Bus accesses are combinational with the update strobe. Each one is due in the same cycle as `upd_en`, so the bus monitor compares at the clock edge that ends that cycle. The bench samples `tdo` at each falling edge. The first bit appears one edge after the capture strobe, and each further bit appears one edge after the shift that moved it. A read result is due one full scan after its own scan. The driver therefore keeps a model of the last read and queues it as the expected frame for the following scan. The monitor flags any bus request that arrives with an empty expectation queue, which is how the update-without-shift cases are checked.

// File: rtl/scanport_pkg.sv
// Package: shared widths and the direction encoding of the scan frame.
// Assumes that the frame is data, then address, then flag, from bit 0 upward.
package scanport_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/scanport_shifter.sv
// Module: serial shift path of the frame.
// On capture it loads the supplied parallel value. On shift it moves tdi in at
// the top and drops bit 0. Capture takes priority over shift.
// Assumes that the strobes are one-cycle enables synchronous to clk.
module scanport_shifter #(
    parameter int FRAME_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic               shift_en,
    input  logic               tdi,
    input  logic [FRAME_W-1:0] load_val,
    output logic [FRAME_W-1:0] frame,
    output logic               tdo
);
    logic [FRAME_W-1:0] sr_q;

    // Shift register: reset, parallel capture, or a one-bit shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (cap_en) begin
            sr_q <= load_val;
        end else if (shift_en) begin
            sr_q <= {tdi, sr_q[FRAME_W-1:1]};
        end
    end

    // Serial output is always the least significant bit.
    always_comb begin
        tdo   = sr_q[0];
        frame = sr_q;
    end
endmodule

// File: rtl/scanport_gate.sv
// Module: decides whether an update strobe may start a bus access.
// A flag is set by any shift cycle and cleared by capture or update. An update
// that finds the flag clear does nothing.
// Assumes that capture and update are never raised in the same cycle.
module scanport_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    output logic fire
);
    logic seen_q;

    // Tracks whether any shift happened since the last capture or update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (cap_en || upd_en) begin
            seen_q <= 1'b0;
        end else if (shift_en) begin
            seen_q <= 1'b1;
        end
    end

    // An access fires only in an update cycle that has a shift behind it.
    always_comb begin
        fire = upd_en && seen_q;
    end
endmodule

// File: rtl/scanport_access.sv
// Module: decodes the shifted frame into a bus access and keeps the read result.
// The read data and its register number are held until the next read, and they
// are offered as the next capture value with the flag bit cleared.
// Assumes that the bus answers a read combinationally in the request cycle.
module scanport_access
    import scanport_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    localparam int FW = DW + AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [FW-1:0] frame,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic [FW-1:0] cap_val
);
    acc_kind_e     kind;
    logic [DW-1:0] hold_data_q;
    logic [AW-1:0] hold_addr_q;

    // Splits the frame into its fields and drives the bus request.
    always_comb begin
        kind      = acc_kind_e'(frame[FW-1]);
        bus_req   = fire;
        bus_wr    = (kind == ACC_WRITE);
        bus_addr  = frame[DW +: AW];
        bus_wdata = frame[DW-1:0];
    end

    // Stores the data and register number of the latest read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data_q <= '0;
            hold_addr_q <= '0;
        end else if (fire && (kind == ACC_READ)) begin
            hold_data_q <= bus_rdata;
            hold_addr_q <= bus_addr;
        end
    end

    // Builds the capture word: flag cleared, then the held register number and data.
    always_comb begin
        cap_val = {1'b0, hold_addr_q, hold_data_q};
    end
endmodule

// File: rtl/scan_reg_port.sv
// Module: top of the scan-chain register access port.
// Connects the shift path, the update gate and the bus access logic.
// Assumes that the strobes come from a controller state machine in the clk domain.
module scan_reg_port
    import scanport_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    localparam int FW = DW + AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          shift_en,
    input  logic          upd_en,
    input  logic          tdi,
    output logic          tdo,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    logic [FW-1:0] frame;
    logic [FW-1:0] cap_val;
    logic          fire;

    scanport_shifter #(.FRAME_W(FW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .tdi      (tdi),
        .load_val (cap_val),
        .frame    (frame),
        .tdo      (tdo)
    );

    scanport_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .upd_en   (upd_en),
        .fire     (fire)
    );

    scanport_access #(.DW(DW), .AW(AW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .frame     (frame),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cap_val   (cap_val)
    );
endmodule

// File: rtl/scanport_chk.sv
// Module: checker for the port-level rules, bound to scan_reg_port.
// It keeps its own shift-seen flag and its own copy of the last read value.
module scanport_chk #(
    parameter int DW = 32,
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cap_en,
    input logic          shift_en,
    input logic          upd_en,
    input logic          tdo,
    input logic          bus_req,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata
);
    logic          c_seen;
    logic [DW-1:0] c_rd;

    // Independent record of shift activity since the last capture or update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 c_seen <= 1'b0;
        else if (cap_en || upd_en)  c_seen <= 1'b0;
        else if (shift_en)          c_seen <= 1'b1;
    end

    // Independent copy of the data returned by the latest read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  c_rd <= '0;
        else if (bus_req && !bus_wr) c_rd <= bus_rdata;
    end

    AST_REQ_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> upd_en); // R3

    AST_REQ_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> c_seen); // R6

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req); // R4

    AST_CAPTURE_RETURNS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !bus_req) |=> (tdo == c_rd[0])); // R5
endmodule

bind scan_reg_port scanport_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .shift_en  (shift_en),
    .upd_en    (upd_en),
    .tdo       (tdo),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_scan_reg_port.sv
module sim_scan_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 7;
    localparam int FW = DW + AW + 1;
    localparam logic [DW-1:0] ID_VAL = 32'h1D00_BEEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
    logic          tdo, bus_req, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .tdi(tdi), .tdo(tdo), .bus_req(bus_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Bus slave: register 0 is a constant ID, register 4 is a counter that
    // advances on each read, and all the other registers are plain storage.
    logic [DW-1:0] mem [128];
    logic [DW-1:0] stream_q;
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        stream_q = 32'h0000_0100;
    end
    assign bus_rdata = (bus_addr == 0) ? ID_VAL :
                       (bus_addr == 4) ? stream_q : mem[bus_addr];
    always @(posedge clk) begin
        if (bus_req && bus_wr && bus_addr != 0 && bus_addr != 4) mem[bus_addr] <= bus_wdata;
        if (bus_req && !bus_wr && bus_addr == 4) stream_q <= stream_q + 1;
    end

    // Scoreboard queues.
    typedef struct { logic wr; logic [AW-1:0] addr; logic [DW-1:0] data; string tag; } bus_item_t;
    typedef struct { logic [FW-1:0] frame; string tag; } frame_item_t;
    bus_item_t   exp_bus[$];
    frame_item_t exp_frm[$];
    logic [FW-1:0] got_frame;
    event frame_ev;

    // Driver-side shadow model, used to compute the expected values.
    logic [DW-1:0] sh_mem [128];
    logic [DW-1:0] sh_stream;
    logic [DW-1:0] last_data;
    logic [AW-1:0] last_addr;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor for bus requests, compared at the edge that ends the update cycle.
    always @(posedge clk) begin
        if (rst_n && bus_req) begin
            if (exp_bus.size() == 0) begin
                check(0, "R6 unexpected bus request", {57'd0, bus_addr}, 64'd0);
            end else begin
                bus_item_t e;
                e = exp_bus.pop_front();
                check(bus_wr == e.wr && bus_addr == e.addr && (!e.wr || bus_wdata == e.data),
                      e.tag, {bus_wr, bus_addr, bus_wdata}, {e.wr, e.addr, e.data});
            end
        end
    end

    // Monitor for frames shifted out by the design.
    initial begin
        forever begin
            frame_item_t e;
            @(frame_ev);
            e = exp_frm.pop_front();
            check(got_frame == e.frame, e.tag, {24'd0, got_frame}, {24'd0, e.frame});
        end
    end

    // Driver: one full scan (capture, 40 shifts, update), with its expectations queued.
    task automatic scan(input logic flag, input logic [AW-1:0] addr, input logic [DW-1:0] data,
                        input string tag);
        logic [FW-1:0] out, got;
        frame_item_t fi;
        bus_item_t   bi;
        out = {flag, addr, data};
        fi.frame = {1'b0, last_addr, last_data};
        fi.tag   = {tag, " R2/R5 frame"};
        exp_frm.push_back(fi);
        bi.wr = flag; bi.addr = addr; bi.data = data; bi.tag = {tag, " R1/R3/R4 bus"};
        exp_bus.push_back(bi);
        if (flag) begin
            if (addr != 0 && addr != 4) sh_mem[addr] = data;
        end else begin
            last_addr = addr;
            if (addr == 0) last_data = ID_VAL;
            else if (addr == 4) begin last_data = sh_stream; sh_stream = sh_stream + 1; end
            else last_data = sh_mem[addr];
        end
        @(negedge clk) cap_en = 1'b1;
        @(negedge clk) begin cap_en = 1'b0; shift_en = 1'b1; end
        for (int i = 0; i < FW; i++) begin
            got[i] = tdo;
            tdi = out[i];
            @(negedge clk);
        end
        shift_en = 1'b0;
        upd_en   = 1'b1;
        @(negedge clk) upd_en = 1'b0;
        got_frame = got;
        ->frame_ev;
    endtask

    // Update strobes with no shift behind them: neither may reach the bus.
    task automatic update_without_shift();
        @(negedge clk) cap_en = 1'b1;
        @(negedge clk) begin cap_en = 1'b0; upd_en = 1'b1; end
        @(negedge clk) upd_en = 1'b1;
        @(negedge clk) upd_en = 1'b0;
        check(exp_bus.size() == 0, "R6 queue after bare updates", exp_bus.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) sh_mem[i] = '0;
        sh_stream = 32'h0000_0100;
        last_data = '0;
        last_addr = '0;
        repeat (3) @(negedge clk);
        check(tdo == 1'b0 && bus_req == 1'b0, "R7 reset outputs", {tdo, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tdo == 1'b0, "R7 tdo after reset", tdo, 0);

        scan(1'b1, 7'd10,  32'hA5A5_0001, "R7 first frame zero; write r10");
        scan(1'b1, 7'd127, 32'hFFFF_0000, "R1 write top address");
        scan(1'b0, 7'd10,  32'h0,         "R4 read r10");
        scan(1'b0, 7'd0,   32'h0,         "R5 dummy read ID returns r10");
        scan(1'b0, 7'd127, 32'h0,         "R1 read r127");
        scan(1'b1, 7'd3,   32'h1234_5678, "R8 write r3");
        scan(1'b0, 7'd0,   32'h0,         "R8 read result kept across write");
        scan(1'b0, 7'd3,   32'h0,         "R3 read back r3");
        scan(1'b0, 7'd4,   32'h0,         "R5 stream 0");
        scan(1'b0, 7'd4,   32'h0,         "R5 stream 1");
        scan(1'b0, 7'd4,   32'h0,         "R5 stream 2");
        scan(1'b0, 7'd0,   32'h0,         "R5 stream close with ID");
        update_without_shift();
        scan(1'b1, 7'd85,  32'h5555_AAAA, "R6 write after bare updates");
        scan(1'b0, 7'd85,  32'h0,         "R2 read alternating bits");
        scan(1'b0, 7'd0,   32'h0,         "R2 close read");

        repeat (4) @(negedge clk);
        check(exp_bus.size() == 0 && exp_frm.size() == 0, "R3 all expectations consumed",
              exp_bus.size() + exp_frm.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule